// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine for 16-bit Pixels

This block draws solid rectangles and copies rectangular regions inside a frame buffer that holds one 16-bit (RGB565) pixel per two bytes. It takes a stream of 32-bit command words. The top eight bits of each word carry an opcode and the remaining bits carry a payload. Parameter words set the destination and source base addresses, the width and height (each given as count minus one), and the fill colour. A start word then launches the job. Memory is reached through a single synchronous port that serves either one read or one write per cycle.

The engine walks each row pixel by pixel and then moves down to the next row. Four flags in the start word can reverse the horizontal or vertical walk of the destination and of the source, each on its own. This lets an overlapping copy pick the safe order, and it also gives mirrored copies. The row pitch, in pixels, comes from a configuration input. While a job runs, `busy` is high and a start word is held off. Parameter words are still accepted during a job, so the next job can be prepared. A one-cycle completion pulse can be requested in the start word.

Top module: `rect_blit_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low, and `cmd_ready` is high whenever the presented word is not a start word.
- R2: Opcode 0x0C loads the destination base and opcode 0x0D loads the source base, both from bits 23:0 with bit 0 forced to zero. Opcode 0x0E loads width minus one and 0x0F loads height minus one, each from bits 9:0. Opcode 0x0B loads the colour from bits 15:0. Any other opcode, except the two start opcodes, changes nothing.
- R3: The byte address of pixel (x, y) is base + (y × `line_pixels` + x) × 2, and every address issued is even.
- R4: Opcode 0x23 starts a fill. The fill writes the colour into all (W+1)×(H+1) pixels, one write per cycle, and `busy` stays high for exactly (W+1)×(H+1) cycles.
- R5: Opcode 0x21 starts a copy. Each pixel is read from the source and then written to the destination in the next cycle, and `busy` stays high for exactly 2×(W+1)×(H+1) cycles.
- R6: In the start word, bit 5 reverses the destination horizontally, bit 4 reverses it vertically, bit 7 reverses the source horizontally and bit 6 reverses it vertically. A reversed axis starts at the far edge and steps backwards. When only one side of an axis is reversed, the copy is mirrored on that axis.
- R7: A copy within a row to a higher address whose regions overlap gives an exact shift when both horizontal reverse flags are set.
- R8: While `busy` is high, a start word sees `cmd_ready` low and is not taken. Parameter words are taken, but they do not alter the job that is running.
- R9: When bit 1 of the start word is set, `done` is high for exactly one cycle, in the first cycle after the job in which `busy` is low. When bit 1 is clear, `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Command word taken at this edge when valid |
| cmd_word | input | 32 | Opcode in bits 31:24, payload below |
| line_pixels | input | 10 | Frame buffer row pitch in pixels |
| busy | output | 1 | A fill or copy is running |
| done | output | 1 | One-cycle completion pulse, if requested |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the pixel |
| mem_wdata | output | 16 | Pixel written |
| mem_rdata | input | 16 | Read data, valid in the cycle after a read |

## Verification
The hardest case to reach is a parameter word that lands while a job is still running, next to a start word that has to be refused in that same window. The bench launches a long fill and, in the middle of it, presents a start word and then a colour word. It checks that the start word is refused and the colour word is taken. It then checks that the running fill kept the old colour and that the next fill picks up the new one. Overlapping copies are also hard to reach, because their result depends on the order of the walk. The bench builds one deliberately, as a right-shift inside a row with both horizontal reverse flags set, and compares the result with a snapshot taken before the copy.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int OPC_W    = 8;
    localparam int CMD_BITS = 32;

    // opcode values carried in the top byte of a command word
    localparam logic [OPC_W-1:0] OPC_COLOUR   = 8'h0B;
    localparam logic [OPC_W-1:0] OPC_DST_BASE = 8'h0C;
    localparam logic [OPC_W-1:0] OPC_SRC_BASE = 8'h0D;
    localparam logic [OPC_W-1:0] OPC_WIDTH    = 8'h0E;
    localparam logic [OPC_W-1:0] OPC_HEIGHT   = 8'h0F;
    localparam logic [OPC_W-1:0] OPC_GO_COPY  = 8'h21;
    localparam logic [OPC_W-1:0] OPC_GO_FILL  = 8'h23;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_READ,
        ST_WRITE
    } seq_state_e;

    typedef enum logic {
        JOB_FILL,
        JOB_COPY
    } job_kind_e;

    typedef struct packed {
        logic irq;
        logic dst_v;
        logic dst_h;
        logic src_v;
        logic src_h;
    } go_flags_t;

    localparam int SIDE_DST = 0;
    localparam int SIDE_SRC = 1;
    localparam int N_SIDES  = 2;

    function automatic logic is_go(input logic [OPC_W-1:0] op);
        return (op == OPC_GO_COPY) || (op == OPC_GO_FILL);
    endfunction

    function automatic go_flags_t decode_flags(input logic [7:0] f);
        go_flags_t r;
        r.irq   = f[1];
        r.dst_v = f[4];
        r.dst_h = f[5];
        r.src_v = f[6];
        r.src_h = f[7];
        return r;
    endfunction

endpackage

// File: rtl/blit_cmd_regs.sv
module blit_cmd_regs
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DIM_W  = 10,
    parameter int PIX_W  = 16,
    parameter int CMD_W  = CMD_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              busy,
    output logic              cmd_ready,
    output logic              start,
    output job_kind_e         start_kind,
    output go_flags_t         start_flags,
    output logic [ADDR_W-1:0] dst_base,
    output logic [ADDR_W-1:0] src_base,
    output logic [DIM_W-1:0]  w_m1,
    output logic [DIM_W-1:0]  h_m1,
    output logic [PIX_W-1:0]  colour
);
    localparam int OPC_LSB = CMD_W - OPC_W;

    logic [OPC_W-1:0] opc;
    logic             go_word;
    logic             accept;

    always_comb begin
        opc         = cmd_word[OPC_LSB +: OPC_W];
        go_word     = is_go(opc);
        cmd_ready   = !(busy && go_word);
        accept      = cmd_valid && cmd_ready;
        start       = accept && go_word;
        start_kind  = (opc == OPC_GO_COPY) ? JOB_COPY : JOB_FILL;
        start_flags = decode_flags(cmd_word[7:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_base <= '0;
            src_base <= '0;
            w_m1     <= '0;
            h_m1     <= '0;
            colour   <= '0;
        end else if (accept) begin
            unique case (opc)
                OPC_DST_BASE: dst_base <= {cmd_word[ADDR_W-1:1], 1'b0};
                OPC_SRC_BASE: src_base <= {cmd_word[ADDR_W-1:1], 1'b0};
                OPC_WIDTH:    w_m1     <= cmd_word[DIM_W-1:0];
                OPC_HEIGHT:   h_m1     <= cmd_word[DIM_W-1:0];
                OPC_COLOUR:   colour   <= cmd_word[PIX_W-1:0];
                default: ;
            endcase
        end
    end

    // R2: base registers never hold an odd byte address
    a_r2_even_bases: assert property (@(posedge clk) disable iff (rst)
        !dst_base[0] && !src_base[0]);

endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int DIM_W  = 10
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DIM_W-1:0]  stride,
    input  logic [DIM_W-1:0]  col,
    input  logic [DIM_W-1:0]  row,
    input  logic [DIM_W-1:0]  w_m1,
    input  logic [DIM_W-1:0]  h_m1,
    input  logic              rev_h,
    input  logic              rev_v,
    output logic [ADDR_W-1:0] addr
);
    localparam int OFS_W = 2 * DIM_W + 2;

    logic [DIM_W-1:0] x;
    logic [DIM_W-1:0] y;
    logic [OFS_W-1:0] pix_ofs;
    logic [OFS_W-1:0] byte_ofs;

    always_comb begin
        x        = rev_h ? (w_m1 - col) : col;
        y        = rev_v ? (h_m1 - row) : row;
        pix_ofs  = OFS_W'(y) * OFS_W'(stride) + OFS_W'(x);
        byte_ofs = pix_ofs << 1;
        addr     = base + ADDR_W'(byte_ofs);
    end

endmodule

// File: rtl/blit_sequencer.sv
module blit_sequencer
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DIM_W  = 10,
    parameter int PIX_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  job_kind_e         start_kind,
    input  go_flags_t         start_flags,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [DIM_W-1:0]  w_m1,
    input  logic [DIM_W-1:0]  h_m1,
    input  logic [PIX_W-1:0]  colour,
    input  logic [DIM_W-1:0]  stride,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata
);
    seq_state_e        state_q;
    go_flags_t         flags_q;
    logic [ADDR_W-1:0] dst_q, src_q;
    logic [DIM_W-1:0]  w_q, h_q;
    logic [PIX_W-1:0]  colour_q;
    logic [DIM_W-1:0]  col_q, row_q;
    logic              done_q;

    logic [ADDR_W-1:0] side_base [N_SIDES];
    logic              side_rh   [N_SIDES];
    logic              side_rv   [N_SIDES];
    logic [ADDR_W-1:0] side_addr [N_SIDES];

    always_comb begin
        side_base[SIDE_DST] = dst_q;
        side_rh[SIDE_DST]   = flags_q.dst_h;
        side_rv[SIDE_DST]   = flags_q.dst_v;
        side_base[SIDE_SRC] = src_q;
        side_rh[SIDE_SRC]   = flags_q.src_h;
        side_rv[SIDE_SRC]   = flags_q.src_v;
    end

    for (genvar g = 0; g < N_SIDES; g++) begin : g_side
        blit_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_gen (
            .base   (side_base[g]),
            .stride (stride),
            .col    (col_q),
            .row    (row_q),
            .w_m1   (w_q),
            .h_m1   (h_q),
            .rev_h  (side_rh[g]),
            .rev_v  (side_rv[g]),
            .addr   (side_addr[g])
        );
    end

    logic last_col, last_row, pixel_done, finish;

    always_comb begin
        last_col   = (col_q == w_q);
        last_row   = (row_q == h_q);
        pixel_done = (state_q == ST_FILL) || (state_q == ST_WRITE);
        finish     = pixel_done && last_col && last_row;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            flags_q  <= '0;
            dst_q    <= '0;
            src_q    <= '0;
            w_q      <= '0;
            h_q      <= '0;
            colour_q <= '0;
            col_q    <= '0;
            row_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        flags_q  <= start_flags;
                        dst_q    <= dst_base;
                        src_q    <= src_base;
                        w_q      <= w_m1;
                        h_q      <= h_m1;
                        colour_q <= colour;
                        col_q    <= '0;
                        row_q    <= '0;
                        state_q  <= (start_kind == JOB_COPY) ? ST_READ : ST_FILL;
                    end
                end
                ST_READ: state_q <= ST_WRITE;
                ST_FILL, ST_WRITE: begin
                    if (finish) begin
                        state_q <= ST_IDLE;
                        done_q  <= flags_q.irq;
                    end else begin
                        if (state_q == ST_WRITE) state_q <= ST_READ;
                        if (last_col) begin
                            col_q <= '0;
                            row_q <= row_q + 1'b1;
                        end else begin
                            col_q <= col_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = done_q;
        mem_req   = busy;
        mem_we    = pixel_done;
        mem_addr  = (state_q == ST_READ) ? side_addr[SIDE_SRC] : side_addr[SIDE_DST];
        mem_wdata = (state_q == ST_FILL) ? colour_q : mem_rdata;
    end

    // R3: every pixel access is halfword aligned
    a_r3_even_addr: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !mem_addr[0]);

    // R5: a source read is always followed by its destination write
    a_r5_read_then_write: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (mem_req && mem_we));

    // R4: the walk never leaves the programmed rectangle
    a_r4_inside_rect: assert property (@(posedge clk) disable iff (rst)
        busy |-> (col_q <= w_q) && (row_q <= h_q));

    // R8: a new job is only launched from idle
    a_r8_start_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R9: completion is a single-cycle pulse right after the job
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DIM_W  = 10,
    parameter int PIX_W  = 16,
    parameter int CMD_W  = CMD_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [DIM_W-1:0]  line_pixels,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata
);
    logic              start;
    job_kind_e         start_kind;
    go_flags_t         start_flags;
    logic [ADDR_W-1:0] dst_base, src_base;
    logic [DIM_W-1:0]  w_m1, h_m1;
    logic [PIX_W-1:0]  colour;

    blit_cmd_regs #(
        .ADDR_W(ADDR_W), .DIM_W(DIM_W), .PIX_W(PIX_W), .CMD_W(CMD_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_word    (cmd_word),
        .busy        (busy),
        .cmd_ready   (cmd_ready),
        .start       (start),
        .start_kind  (start_kind),
        .start_flags (start_flags),
        .dst_base    (dst_base),
        .src_base    (src_base),
        .w_m1        (w_m1),
        .h_m1        (h_m1),
        .colour      (colour)
    );

    blit_sequencer #(
        .ADDR_W(ADDR_W), .DIM_W(DIM_W), .PIX_W(PIX_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_kind  (start_kind),
        .start_flags (start_flags),
        .dst_base    (dst_base),
        .src_base    (src_base),
        .w_m1        (w_m1),
        .h_m1        (h_m1),
        .colour      (colour),
        .stride      (line_pixels),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .done        (done),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

endmodule

// File: tb/test_rect_blit_engine.sv
module test_rect_blit_engine;

    localparam int MEM_WORDS = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_word = '0;
    logic [9:0]  line_pixels = 10'd16;
    logic        busy, done, mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    logic        bd_we = 1'b0;
    logic [9:0]  bd_addr = '0;
    logic [15:0] bd_data = '0;

    logic [15:0] mem   [MEM_WORDS];
    logic [15:0] model [MEM_WORDS];
    logic [15:0] snap  [MEM_WORDS];

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rect_blit_engine i_rect_blit_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .line_pixels(line_pixels), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (bd_we) mem[bd_addr] <= bd_data;
        else if (mem_req) begin
            if (mem_we) mem[mem_addr[10:1]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[10:1]];
        end
    end

    typedef struct packed {
        logic        copy;
        logic [7:0]  flags;
        logic [15:0] dst;
        logic [15:0] src;
        logic [9:0]  wm1;
        logic [9:0]  hm1;
        logic [9:0]  stride;
        logic [15:0] colour;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h02, 16'h0040, 16'h0000, 10'd3, 10'd2, 10'd16, 16'hF800},
        '{1'b0, 8'h00, 16'h0101, 16'h0000, 10'd0, 10'd0, 10'd32, 16'h07E0},
        '{1'b1, 8'h02, 16'h0400, 16'h0200, 10'd4, 10'd3, 10'd20, 16'h0000},
        '{1'b1, 8'h20, 16'h0500, 16'h0200, 10'd5, 10'd1, 10'd24, 16'h0000},
        '{1'b1, 8'h12, 16'h0600, 16'h0100, 10'd2, 10'd3, 10'd16, 16'h0000},
        '{1'b1, 8'hF0, 16'h0700, 16'h0300, 10'd3, 10'd2, 10'd16, 16'h0000},
        '{1'b0, 8'h32, 16'h0080, 16'h0000, 10'd9, 10'd1, 10'd40, 16'h001F}
    };

    task automatic check(input string req, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic load(input logic [7:0] op, input logic [23:0] payload);
        send({op, payload});
    endtask

    task automatic init_mem(input int seed);
        for (int k = 0; k < MEM_WORDS; k++) begin
            @(negedge clk);
            bd_we   = 1'b1;
            bd_addr = 10'(k);
            bd_data = 16'(k * 37 + seed * 101) ^ 16'hA5A5;
            model[k] = bd_data;
        end
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic model_job(input logic copy, input logic [7:0] fl, input int dst, input int src,
                             input int w, input int h, input int stride, input logic [15:0] col);
        for (int j = 0; j <= h; j++) begin
            for (int i = 0; i <= w; i++) begin
                int dx, dy, sx, sy, da, sa;
                dx = fl[5] ? w - i : i;
                dy = fl[4] ? h - j : j;
                sx = fl[7] ? w - i : i;
                sy = fl[6] ? h - j : j;
                da = ((dst >> 1) + dy * stride + dx) % MEM_WORDS;
                sa = ((src >> 1) + sy * stride + sx) % MEM_WORDS;
                model[da] = copy ? model[sa] : col;
            end
        end
    endtask

    // launch a job, return busy cycles and done seen on busy falling
    task automatic run_go(input logic copy, input logic [7:0] fl, output int cyc, output int dn);
        send({copy ? 8'h21 : 8'h23, 16'h0000, fl});
        cyc = 0;
        while (busy) begin
            @(posedge clk);
            #1;
            cyc++;
        end
        dn = int'(done);
        @(posedge clk);
        #1;
    endtask

    task automatic compare(input string req, input string what);
        int bad = 0;
        int first = -1;
        for (int k = 0; k < MEM_WORDS; k++) begin
            if (mem[k] !== model[k]) begin
                bad++;
                if (first < 0) first = k;
            end
        end
        check(req, bad, 0, $sformatf("%s mismatching words (first at %0d)", what, first));
    endtask

    initial begin
        int cyc, dn, n;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(busy), 0, "busy after reset");
        check("R1", int'(done), 0, "done after reset");
        check("R1", int'(mem_req), 0, "mem_req after reset");
        check("R1", int'(cmd_ready), 1, "cmd_ready after reset");

        // table of jobs: R2 R3 R4 R5 R6 R9
        for (int v = 0; v < NV; v++) begin
            init_mem(v);
            line_pixels = VEC[v].stride;
            load(8'h0C, 24'(VEC[v].dst));
            load(8'h0D, 24'(VEC[v].src));
            load(8'h0E, 24'(VEC[v].wm1));
            load(8'h0F, 24'(VEC[v].hm1));
            load(8'h0B, 24'(VEC[v].colour));
            model_job(VEC[v].copy, VEC[v].flags, int'(VEC[v].dst), int'(VEC[v].src),
                      int'(VEC[v].wm1), int'(VEC[v].hm1), int'(VEC[v].stride), VEC[v].colour);
            run_go(VEC[v].copy, VEC[v].flags, cyc, dn);
            n = (int'(VEC[v].wm1) + 1) * (int'(VEC[v].hm1) + 1);
            if (VEC[v].copy) begin
                check("R5", cyc, 2 * n, $sformatf("vector %0d copy busy cycles", v));
                compare("R6", $sformatf("vector %0d copy", v));
            end else begin
                check("R4", cyc, n, $sformatf("vector %0d fill busy cycles", v));
                compare("R3", $sformatf("vector %0d fill", v));
            end
            check("R9", dn, int'(VEC[v].flags[1]), $sformatf("vector %0d done", v));
        end

        // R2: unknown opcodes leave parameters untouched
        init_mem(20);
        line_pixels = 10'd16;
        load(8'h0C, 24'h000200);
        load(8'h0E, 24'd2);
        load(8'h0F, 24'd1);
        load(8'h0B, 24'h00ABCD);
        load(8'h05, 24'hFFFFFF);
        load(8'h1B, 24'h001234);
        load(8'h2E, 24'h0003FF);
        model_job(1'b0, 8'h00, 'h200, 0, 2, 1, 16, 16'hABCD);
        run_go(1'b0, 8'h00, cyc, dn);
        check("R2", cyc, 6, "fill size after unknown opcodes");
        compare("R2", "fill after unknown opcodes");

        // R8: start refused while busy, parameter taken but applied only to next job
        init_mem(21);
        load(8'h0C, 24'h000000);
        load(8'h0E, 24'd15);
        load(8'h0F, 24'd7);
        load(8'h0B, 24'h001111);
        send({8'h23, 24'h000002});
        check("R8", int'(busy), 1, "busy after long fill start");
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = {8'h21, 24'h0};
        #1;
        check("R8", int'(cmd_ready), 0, "ready for start word while busy");
        cmd_word  = {8'h0B, 24'h002222};
        #1;
        check("R8", int'(cmd_ready), 1, "ready for colour word while busy");
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        while (busy) begin
            @(posedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        model_job(1'b0, 8'h00, 0, 0, 15, 7, 16, 16'h1111);
        compare("R8", "running fill kept old colour");
        model_job(1'b0, 8'h00, 0, 0, 15, 7, 16, 16'h2222);
        run_go(1'b0, 8'h00, cyc, dn);
        compare("R8", "next fill uses colour loaded while busy");
        check("R9", dn, 0, "done without irq flag");

        // R7: overlapping right shift inside a row, both horizontal reverse flags
        init_mem(22);
        line_pixels = 10'd32;
        for (int k = 0; k < MEM_WORDS; k++) snap[k] = model[k];
        load(8'h0D, 24'd200);
        load(8'h0C, 24'd204);
        load(8'h0E, 24'd7);
        load(8'h0F, 24'd0);
        run_go(1'b1, 8'hA0, cyc, dn);
        begin
            int bad = 0;
            for (int k = 0; k < 8; k++) if (mem[102 + k] !== snap[100 + k]) bad++;
            check("R7", bad, 0, "overlapped shift mismatches");
        end
        check("R7", int'(mem[100]), int'(snap[100]), "word left of destination untouched");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule